// File: doc/BRIEF.md
# Exact-Length Acknowledge Packet Detector

This block watches a byte stream that a host link delivers one byte per cycle and marks the final byte of each packet. It raises a pending-acknowledge flag only when a packet holds exactly four bytes and those bytes are 0x40, 0x00, 0x00, 0x00, received in that order. A packet that only begins with those bytes is rejected: a settings value such as the big-endian double 2.0 starts with the same four bytes, and it must not count as an operator acknowledge. The link-state input has no effect, so an acknowledge is accepted whatever the connection state is.

A system that has entered a safe emergency hold sets the emergency input and strobes a periodic check tick, nominally every 250 ms. On a tick during emergency, a pending acknowledge is consumed. The flag drops and a one-cycle clear-emergency pulse is issued, so the system leaves the hold without a reset. With no acknowledge pending, ticks never produce the pulse and the hold lasts for any number of iterations. Each acknowledge can clear the emergency only once.

Top module: `ack_detect_top`

## Requirements
- R1: After reset, `ack_pending` and `emerg_clear` are both 0.
- R2: A packet of exactly four valid bytes 0x40, 0x00, 0x00, 0x00 (first byte received first, `rx_last` high on the fourth) sets `ack_pending` on the clock edge that samples the fourth byte.
- R3: A packet of five or more bytes never sets `ack_pending`, even when its first four bytes are 0x40, 0x00, 0x00, 0x00. Lengths beyond four saturate internally and stay rejected.
- R4: A packet of one, two or three bytes never sets `ack_pending`, even when its bytes match the start of the pattern.
- R5: A four-byte packet with any byte different from the pattern never sets `ack_pending`. This includes an opcode byte other than 0x40.
- R6: The value of `link_state` has no effect on detection, including when it changes partway through a packet.
- R7: On a clock edge where `chk_tick`, `emerg_active` and `ack_pending` are all 1, `ack_pending` clears and `emerg_clear` is 1 for exactly the following cycle. Later ticks with no new acknowledge produce no further pulse.
- R8: While no acknowledge is pending, `emerg_clear` stays 0 on every tick, however many ticks occur in emergency.
- R9: A pending acknowledge is held, unchanged, across ticks taken while `emerg_active` is 0, and it is consumed by the first tick in emergency.
- R10: Each `rx_last` byte ends a packet, and counting restarts with the next valid byte. A correct acknowledge is detected directly after a rejected long or short packet.
- R11: Cycles with `rx_valid` low inside a packet are not counted as bytes, and the values on `rx_data` and `rx_last` during those cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A packet byte is present on `rx_data` |
| rx_data | input | 8 | Packet byte |
| rx_last | input | 1 | Qualified by `rx_valid`: this byte ends the packet |
| link_state | input | 2 | Host link connection state, ignored |
| emerg_active | input | 1 | System is in the emergency hold |
| chk_tick | input | 1 | One-cycle strobe for the periodic hold-loop check |
| ack_pending | output | 1 | Latched acknowledge waiting to be consumed |
| emerg_clear | output | 1 | One-cycle pulse requesting exit from emergency |

## Verification
`ack_pending` is registered once after the data path. It therefore changes on the same edge that samples the last byte of a packet, and it is visible at the falling edge that follows. `emerg_clear` also comes from one register: it is high for the single cycle after the tick edge that consumes the flag, and `ack_pending` reads 0 in that same cycle. The bench applies every input just after a falling edge and reads the outputs at the next falling edge. Because of this, each expectation is checked exactly one register stage after the edge that carries its stimulus. A few checks also confirm that the pulse has fallen one cycle later.

// File: rtl/ackdet_pkg.sv
package ackdet_pkg;

    // Default geometry of the acknowledge command
    localparam int unsigned ACK_BYTES  = 4;
    localparam int unsigned ACK_BYTE_W = 8;
    localparam logic [ACK_BYTES*ACK_BYTE_W-1:0] ACK_WORD = 32'h4000_0000;
    localparam int unsigned LINK_W     = 2;

    // Register image of the acknowledge latch / consume stage
    typedef struct packed {
        logic pend;   // acknowledge waiting
        logic clr;    // clear-emergency pulse
    } ack_state_t;

endpackage

// File: rtl/ackdet_len_match.sv
// Tracks the byte position inside the current packet and whether every
// byte so far equals the command pattern; flags a hit on the closing byte
// of a packet of exactly PKT_BYTES matching bytes.
module ackdet_len_match #(
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned PKT_BYTES = 4,
    parameter logic [PKT_BYTES*BYTE_W-1:0] PATTERN = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [BYTE_W-1:0] data,
    input  logic              last,
    output logic              hit
);
    localparam int unsigned CNT_W = $clog2(PKT_BYTES + 2);
    localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(PKT_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(PKT_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;    // bytes seen so far, saturating
        logic             match;  // all bytes so far equal the pattern
    } pos_state_t;

    pos_state_t st_q, st_d;

    // Pattern bytes, first received byte is the most significant
    logic [BYTE_W-1:0] exp_byte [PKT_BYTES];
    for (genvar g = 0; g < PKT_BYTES; g++) begin : g_exp
        assign exp_byte[g] = PATTERN[(PKT_BYTES-1-g)*BYTE_W +: BYTE_W];
    end

    logic [BYTE_W-1:0] exp_sel;
    logic              in_range;
    logic              byte_ok;
    logic              run_ok;

    always_comb begin
        exp_sel  = '0;
        in_range = 1'b0;
        for (int i = 0; i < PKT_BYTES; i++) begin
            if (st_q.cnt == CNT_W'(i)) begin
                exp_sel  = exp_byte[i];
                in_range = 1'b1;
            end
        end
        byte_ok = in_range && (data == exp_sel);
        run_ok  = st_q.match && byte_ok;
        hit     = vld && last && (st_q.cnt == LAST_POS) && run_ok;

        st_d = st_q;
        if (vld) begin
            if (last) begin
                st_d.cnt   = '0;
                st_d.match = 1'b1;
            end else begin
                st_d.cnt   = (st_q.cnt == SAT_CNT) ? st_q.cnt : st_q.cnt + 1'b1;
                st_d.match = run_ok;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.match <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: the closing byte of a packet restarts the count
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vld && last |=> (st_q.cnt == '0) && st_q.match);

    // R3: the position count never runs past its saturation value
    p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= SAT_CNT);

    // R11: idle cycles leave the packet position untouched
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(st_q));

    // R3: a packet whose count passed the command length cannot hit
    p_long_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= CNT_W'(PKT_BYTES)) |-> !hit);

endmodule

// File: rtl/ackdet_flag_ctl.sv
// Latches an acknowledge and consumes it on a periodic check taken in
// emergency, issuing a one-cycle clear pulse.
module ackdet_flag_ctl
    import ackdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic tick,
    input  logic emerg,
    output logic pend,
    output logic clr
);
    ack_state_t st_q, st_d;
    logic       consume;

    always_comb begin
        consume    = tick && emerg && st_q.pend;
        st_d.clr   = consume;
        // a fresh hit in the consuming cycle stays pending for a later tick
        st_d.pend  = hit || (st_q.pend && !consume);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign clr  = st_q.clr;

    // R7: a clear pulse only follows a tick in emergency with a pending ack
    p_clr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> $past(tick && emerg && pend));

    // R7: consumption drops the flag and raises the pulse
    p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick && emerg && pend && !hit |=> !pend && clr);

    // R9: without a tick in emergency, a pending ack is held
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !(tick && emerg) |=> pend);

    // R2: the flag rises only from a detected packet
    p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend && !hit |=> !pend);

    // R8: with nothing pending, no tick produces a pulse
    p_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !clr);

endmodule

// File: rtl/ackdet_top.sv
module ack_detect_top
    import ackdet_pkg::*;
#(
    parameter int unsigned BYTE_W    = ACK_BYTE_W,
    parameter int unsigned PKT_BYTES = ACK_BYTES,
    parameter logic [PKT_BYTES*BYTE_W-1:0] CMD_PATTERN = ACK_WORD,
    parameter int unsigned LINK_BITS = LINK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_data,
    input  logic                 rx_last,
    input  logic [LINK_BITS-1:0] link_state,
    input  logic                 emerg_active,
    input  logic                 chk_tick,
    output logic                 ack_pending,
    output logic                 emerg_clear
);
    logic pkt_hit;

    // Detection is independent of the link connection state
    logic link_unused;
    assign link_unused = ^link_state;

    ackdet_len_match #(
        .BYTE_W   (BYTE_W),
        .PKT_BYTES(PKT_BYTES),
        .PATTERN  (CMD_PATTERN)
    ) u_match (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  (rx_valid),
        .data (rx_data),
        .last (rx_last),
        .hit  (pkt_hit)
    );

    ackdet_flag_ctl u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .hit  (pkt_hit),
        .tick (chk_tick),
        .emerg(emerg_active),
        .pend (ack_pending),
        .clr  (emerg_clear)
    );

    // R1: outputs are idle in the first cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !ack_pending && !emerg_clear);

    // R7: pulse lasts one cycle unless a back-to-back consume follows
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        emerg_clear && !ack_pending |=> !emerg_clear);

endmodule

// File: tb/tb_ack_detect_top.sv
module tb_ack_detect_top;
    localparam int unsigned CMD = 32'h4000_0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_last = 1'b0;
    logic [1:0] link_state = 2'd0;
    logic       emerg_active = 1'b0;
    logic       chk_tick = 1'b0;
    logic       ack_pending;
    logic       emerg_clear;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] pkt [16];

    always #4 clk = ~clk;   // 125 MHz

    ack_detect_top dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .link_state(link_state), .emerg_active(emerg_active),
        .chk_tick(chk_tick), .ack_pending(ack_pending), .emerg_clear(emerg_clear)
    );

    function automatic logic [7:0] cmd_byte(int i);
        return 8'((CMD >> (8 * (3 - i))) & 32'hFF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_cmd(int n);
        for (int i = 0; i < 16; i++) pkt[i] = (i < 4) ? cmd_byte(i) : 8'h00;
        if (n < 0) pkt[0] = 8'h40;
    endtask

    // Drive n bytes from pkt, with gap idle cycles (junk on data/last)
    // between bytes; returns at the negedge after the last byte's edge.
    task automatic send(int n, int gap, bit walk_link);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pkt[i]; rx_last = (i == n - 1);
            if (walk_link) link_state = 2'(i);
            if (i != n - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    rx_valid = 1'b0; rx_data = 8'h40; rx_last = 1'b1;
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_data = 8'h00;
    endtask

    // Tick in emergency; flag must drop and one pulse appear
    task automatic consume(string req);
        emerg_active = 1'b1; chk_tick = 1'b1;
        @(negedge clk);
        chk_tick = 1'b0;
        chk({req, " clear pulse"}, emerg_clear, 1);
        chk({req, " flag consumed"}, ack_pending, 0);
        @(negedge clk);
        chk({req, " pulse one cycle"}, emerg_clear, 0);
        emerg_active = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pending after reset", ack_pending, 0);
        chk("R1 clear after reset", emerg_clear, 0);

        // Length sweep with matching prefix: only length 4 hits
        for (int n = 1; n <= 8; n++) begin
            load_cmd(0);
            link_state = 2'(n);
            send(n, 0, 1'b0);
            if (n == 4) begin
                chk("R2 exact ack sets flag", ack_pending, 1);
                consume("R7 after exact ack");
            end else if (n > 4) chk("R3 long packet rejected", ack_pending, 0);
            else chk("R4 short packet rejected", ack_pending, 0);
        end

        // Single-byte corruption sweep over every position and value
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 256; v++) begin
                load_cmd(0);
                pkt[p] = 8'(v);
                send(4, 0, 1'b0);
                if (8'(v) == cmd_byte(p)) begin
                    chk("R5 matching byte hits", ack_pending, 1);
                    consume("R7 sweep");
                end else begin
                    chk("R5 wrong byte rejected", ack_pending, 0);
                end
            end
        end

        // Link state: fixed values and walking within a packet
        for (int k = 0; k < 4; k++) begin
            load_cmd(0);
            link_state = 2'(k);
            send(4, 0, 1'b0);
            chk("R6 fixed link state", ack_pending, 1);
            consume("R6");
            send(4, 0, 1'b1);
            chk("R6 link changing mid packet", ack_pending, 1);
            consume("R6");
        end

        // Idle gaps inside packets
        for (int g = 1; g <= 3; g++) begin
            load_cmd(0);
            send(4, g, 1'b0);
            chk("R11 gapped ack hits", ack_pending, 1);
            consume("R11");
            send(3, g, 1'b0);
            chk("R11 gapped short rejected", ack_pending, 0);
            send(5, g, 1'b0);
            chk("R11 gapped long rejected", ack_pending, 0);
        end

        // Restart after rejected packets
        load_cmd(0);
        send(12, 0, 1'b0);
        send(4, 0, 1'b0);
        chk("R10 ack after long packet", ack_pending, 1);
        consume("R10");
        send(2, 0, 1'b0);
        send(4, 0, 1'b0);
        chk("R10 ack after short packet", ack_pending, 1);
        consume("R10");

        // Hold without ack across many iterations
        emerg_active = 1'b1;
        for (int t = 0; t < 40; t++) begin
            chk_tick = 1'b1;
            @(negedge clk);
            chk_tick = 1'b0;
            chk("R8 no pulse without ack", emerg_clear, 0);
            @(negedge clk);
        end
        emerg_active = 1'b0;

        // Ack held while not in emergency, then consumed once
        send(4, 0, 1'b0);
        for (int t = 0; t < 10; t++) begin
            chk_tick = 1'b1;
            @(negedge clk);
            chk_tick = 1'b0;
            chk("R9 flag held outside emergency", ack_pending, 1);
            chk("R9 no pulse outside emergency", emerg_clear, 0);
        end
        consume("R9");
        emerg_active = 1'b1;
        for (int t = 0; t < 5; t++) begin
            chk_tick = 1'b1;
            @(negedge clk);
            chk_tick = 1'b0;
            chk("R7 single clear per ack", emerg_clear, 0);
        end
        emerg_active = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule